// File: doc/BRIEF.md
# Guarded Data-EEPROM Access Controller

This block is the register-level control path in front of a small on-chip byte store that stands in for nonvolatile data cells. A host reaches three registers over a simple single-cycle write bus with a combinational read port. The registers are a cell address, a data byte and a control byte. Software loads the address (and, for a write, the data), sets an enable bit in the control byte, and then sets the matching start bit. The start bit stays at 1 while the timed operation runs, and hardware clears it when the operation ends, so software polls that bit to find completion. Read results are placed in the data register.

Writes are guarded. A write cycle can start only when the control write that sets write-start directly follows a control write that set write-enable. The control byte can be reached only while the bank-select input is 1. A low-power request that arrives during an operation aborts it. The store is then left untouched and a failure output is raised.

Top module: `nvm_ctrl_unit`

## Requirements
- R1: After reset the address, data and control registers read 0, the byte store holds 0 at every address, and `fail_flag` is 0.
- R2: Bus register select encoding is 0 = address, 1 = data, 2 = control, 3 = unused (reads 0). While `bank_sel` is 0, control writes are ignored and control reads return 0. Address and data registers do not depend on `bank_sel`.
- R3: The control byte fields are bit 0 read-busy/start, bit 1 read-enable, bit 2 write-busy/start and bit 3 write-enable. A control write with bit 0 = 1 starts a read only if read-enable was already 1 before that write.
- R4: A read keeps bit 0 at 1 for exactly RD_CYCLES (2) clocks. Bit 0 then returns to 0 and the data register holds the byte at the latched address.
- R5: A write starts only when a control write with bits 3 and 2 both 1 directly follows, as the next bus write of any kind, an accepted control write with bit 3 = 1. Any other ordering starts nothing.
- R6: A write keeps bit 2 at 1 for exactly WR_CYCLES (32) clocks. Bit 2 then returns to 0 and the byte from the data register is stored at the latched address.
- R7: Writing 0 to the control byte clears both enable bits, and a later write-start then does nothing.
- R8: While an operation is running, new start requests are ignored. Changes to the address or data register do not alter the running operation.
- R9: If `lp_req` is 1 at a clock edge during an operation, the operation ends at that edge without touching the store and `fail_flag` goes to 1. The flag stays at 1 until the next operation starts.
- R10: `lp_req` has no effect while no operation is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_sel | input | 1 | Bank selector; 1 makes the control byte reachable |
| bus_we | input | 1 | Register write strobe |
| bus_sel | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data of the selected register |
| lp_req | input | 1 | Sleep/idle entry request |
| fail_flag | output | 1 | Last operation was aborted |

## Verification
Assertions check these rules on every cycle. A start needs its enable bit and, for a write, the arming write. No start is granted while busy. The latched address holds still during an operation. A low-power abort clears busy and sets the failure flag on the next edge. Bank-0 control writes and zero control writes act on the enable bits as required. Some behaviour only the bench's scenarios can show. This covers the exact duration of each operation as seen by polling, and the store contents after writes, aborted writes and reads with disturbed registers. It also covers broken unlock orderings, since these need sequences of bus traffic and read-back through the bus.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_DATA = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // control byte bit positions
    localparam int unsigned CB_RD_GO = 0;
    localparam int unsigned CB_RD_EN = 1;
    localparam int unsigned CB_WR_GO = 2;
    localparam int unsigned CB_WR_EN = 3;

    typedef struct packed {
        logic wr_en;
        logic wr_go;
        logic rd_en;
        logic rd_go;
    } ctrl_view_t;

    function automatic ctrl_view_t make_view(logic rd_en, logic wr_en, op_e op);
        ctrl_view_t v;
        v.wr_en = wr_en;
        v.wr_go = (op == OP_WRITE);
        v.rd_en = rd_en;
        v.rd_go = (op == OP_READ);
        return v;
    endfunction

endpackage

// File: rtl/nvm_array.sv
module nvm_array #(
    parameter int unsigned AW = 6,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst) begin
                cells[g] <= '0;
            end else if (we && (addr == AW'(g))) begin
                cells[g] <= wdata;
            end
        end
    end

    assign rdata = cells[addr];

endmodule

// File: rtl/nvm_seq.sv
module nvm_seq
    import nvm_pkg::*;
#(
    parameter int unsigned AW        = 6,
    parameter int unsigned DW        = 8,
    parameter int unsigned WR_CYCLES = 32,
    parameter int unsigned RD_CYCLES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_rd,
    input  logic          start_wr,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] data_in,
    input  logic          lp_req,
    output op_e           op,
    output logic          busy,
    output logic          rd_done,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          fail
);
    localparam int unsigned MAXC = (WR_CYCLES > RD_CYCLES) ? WR_CYCLES : RD_CYCLES;
    localparam int unsigned CW   = $clog2(MAXC + 1);

    op_e           op_q;
    logic [CW-1:0] cnt_q;
    logic [AW-1:0] a_q;
    logic [DW-1:0] d_q;
    logic          fail_q;
    logic          last;

    assign busy = (op_q != OP_IDLE);
    assign last = busy && !lp_req && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= OP_IDLE;
            cnt_q  <= '0;
            a_q    <= '0;
            d_q    <= '0;
            fail_q <= 1'b0;
        end else if (busy) begin
            if (lp_req) begin
                op_q   <= OP_IDLE;
                fail_q <= 1'b1;
            end else if (cnt_q == '0) begin
                op_q <= OP_IDLE;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end else if (start_wr) begin
            op_q   <= OP_WRITE;
            cnt_q  <= CW'(WR_CYCLES - 1);
            a_q    <= addr_in;
            d_q    <= data_in;
            fail_q <= 1'b0;
        end else if (start_rd) begin
            op_q   <= OP_READ;
            cnt_q  <= CW'(RD_CYCLES - 1);
            a_q    <= addr_in;
            fail_q <= 1'b0;
        end
    end

    assign op        = op_q;
    assign rd_done   = last && (op_q == OP_READ);
    assign mem_we    = last && (op_q == OP_WRITE);
    assign mem_addr  = a_q;
    assign mem_wdata = d_q;
    assign fail      = fail_q;

    p_abort_ends_op_r9: assert property (@(posedge clk) disable iff (rst)
        busy && lp_req |=> !busy && fail);

    p_latched_addr_hold_r8: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(a_q));

    p_finish_goes_idle_r4: assert property (@(posedge clk) disable iff (rst)
        busy && !lp_req && (cnt_q == '0) |=> !busy);

    p_idle_lp_no_fail_r10: assert property (@(posedge clk) disable iff (rst)
        !busy && !start_rd && !start_wr |=> $stable(fail_q));

endmodule

// File: rtl/nvm_regs.sv
module nvm_regs
    import nvm_pkg::*;
#(
    parameter int unsigned AW = 6,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bank_sel,
    input  logic          bus_we,
    input  logic [1:0]    bus_sel,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  op_e           op,
    input  logic          busy,
    input  logic          rd_done,
    input  logic [DW-1:0] rd_byte,
    output logic          start_rd,
    output logic          start_wr,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] data_q
);
    reg_sel_e   sel;
    logic       ctrl_wr;
    logic       rd_en_q;
    logic       wr_en_q;
    logic       armed_q;
    ctrl_view_t view;

    assign sel     = reg_sel_e'(bus_sel);
    assign ctrl_wr = bus_we && bank_sel && (sel == SEL_CTRL);

    assign start_wr = ctrl_wr && !busy && armed_q
                    && bus_wdata[CB_WR_EN] && bus_wdata[CB_WR_GO];
    assign start_rd = ctrl_wr && !busy && !start_wr
                    && rd_en_q && bus_wdata[CB_RD_GO];

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            data_q  <= '0;
            rd_en_q <= 1'b0;
            wr_en_q <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            if (bus_we) begin
                armed_q <= ctrl_wr && bus_wdata[CB_WR_EN];
            end
            if (ctrl_wr) begin
                rd_en_q <= bus_wdata[CB_RD_EN];
                wr_en_q <= bus_wdata[CB_WR_EN];
            end
            if (bus_we && (sel == SEL_ADDR)) begin
                addr_q <= bus_wdata[AW-1:0];
            end
            if (rd_done) begin
                data_q <= rd_byte;
            end else if (bus_we && (sel == SEL_DATA)) begin
                data_q <= bus_wdata;
            end
        end
    end

    assign view = make_view(rd_en_q, wr_en_q, op);

    always_comb begin
        unique case (sel)
            SEL_ADDR: bus_rdata = DW'(addr_q);
            SEL_DATA: bus_rdata = data_q;
            SEL_CTRL: bus_rdata = bank_sel ? DW'(view) : '0;
            default:  bus_rdata = '0;
        endcase
    end

    p_rd_start_needs_en_r3: assert property (@(posedge clk) disable iff (rst)
        start_rd |-> rd_en_q);

    p_wr_start_needs_arm_r5: assert property (@(posedge clk) disable iff (rst)
        start_wr |-> wr_en_q && armed_q);

    p_bank0_ctrl_ignored_r2: assert property (@(posedge clk) disable iff (rst)
        bus_we && !bank_sel && (sel == SEL_CTRL) |=> $stable({rd_en_q, wr_en_q}));

    p_zero_ctrl_clears_r7: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr && (bus_wdata == '0) |=> !rd_en_q && !wr_en_q);

    p_no_start_when_busy_r8: assert property (@(posedge clk) disable iff (rst)
        busy |-> !(start_rd || start_wr));

endmodule

// File: rtl/nvm_ctrl_unit.sv
module nvm_ctrl_unit
    import nvm_pkg::*;
#(
    parameter int unsigned AW        = 6,
    parameter int unsigned DW        = 8,
    parameter int unsigned WR_CYCLES = 32,
    parameter int unsigned RD_CYCLES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bank_sel,
    input  logic          bus_we,
    input  logic [1:0]    bus_sel,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          lp_req,
    output logic          fail_flag
);
    op_e           op;
    logic          busy;
    logic          rd_done;
    logic          start_rd;
    logic          start_wr;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;

    nvm_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bank_sel  (bank_sel),
        .bus_we    (bus_we),
        .bus_sel   (bus_sel),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .op        (op),
        .busy      (busy),
        .rd_done   (rd_done),
        .rd_byte   (mem_rdata),
        .start_rd  (start_rd),
        .start_wr  (start_wr),
        .addr_q    (addr_q),
        .data_q    (data_q)
    );

    nvm_seq #(.AW(AW), .DW(DW), .WR_CYCLES(WR_CYCLES), .RD_CYCLES(RD_CYCLES)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_rd  (start_rd),
        .start_wr  (start_wr),
        .addr_in   (addr_q),
        .data_in   (data_q),
        .lp_req    (lp_req),
        .op        (op),
        .busy      (busy),
        .rd_done   (rd_done),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .fail      (fail_flag)
    );

    nvm_array #(.AW(AW), .DW(DW)) u_array (
        .clk   (clk),
        .rst   (rst),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

endmodule

// File: tb/test_nvm_ctrl_unit.sv
module test_nvm_ctrl_unit;

    localparam int WRC = 32;
    localparam int RDC = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bank_sel = 1'b1;
    logic       bus_we = 1'b0;
    logic [1:0] bus_sel = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       lp_req = 1'b0;
    logic       fail_flag;

    int n_chk = 0;
    int n_fail = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    nvm_ctrl_unit i_nvm_ctrl_unit (
        .clk(clk), .rst(rst), .bank_sel(bank_sel), .bus_we(bus_we),
        .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .lp_req(lp_req), .fail_flag(fail_flag)
    );

    // behavioural reference model
    int m_mem [64];
    int m_addr, m_data, m_op, m_cnt, m_oa, m_od;
    bit m_rden, m_wren, m_arm, m_fail;

    always @(posedge clk) begin
        bit bsy, cw, swr, srd, rdone;
        if (rst) begin
            foreach (m_mem[i]) m_mem[i] = 0;
            m_addr = 0; m_data = 0; m_op = 0; m_cnt = 0; m_oa = 0; m_od = 0;
            m_rden = 0; m_wren = 0; m_arm = 0; m_fail = 0;
        end else begin
            bsy = (m_op != 0);
            rdone = 0;
            if (bsy) begin
                if (lp_req) begin m_op = 0; m_fail = 1; end
                else if (m_cnt == 0) begin
                    if (m_op == 1) rdone = 1; else m_mem[m_oa] = m_od;
                    if (m_op == 1) m_data = m_mem[m_oa];
                    m_op = 0;
                end else m_cnt--;
            end
            cw  = bus_we && bank_sel && bus_sel == 2'd2;
            swr = cw && !bsy && m_arm && bus_wdata[3] && bus_wdata[2];
            srd = cw && !bsy && !swr && m_rden && bus_wdata[0];
            if (swr) begin m_op = 2; m_cnt = WRC - 1; m_oa = m_addr; m_od = m_data; m_fail = 0; end
            if (srd) begin m_op = 1; m_cnt = RDC - 1; m_oa = m_addr; m_fail = 0; end
            if (bus_we) m_arm = cw && bus_wdata[3];
            if (cw) begin m_rden = bus_wdata[1]; m_wren = bus_wdata[3]; end
            if (bus_we && bus_sel == 2'd0) m_addr = int'(bus_wdata[5:0]);
            if (bus_we && bus_sel == 2'd1 && !rdone) m_data = int'(bus_wdata);
        end
    end

    function automatic logic [7:0] m_rdata();
        case (bus_sel)
            2'd0: return 8'(m_addr);
            2'd1: return 8'(m_data);
            2'd2: return bank_sel ? {4'd0, m_wren, m_op == 2, m_rden, m_op == 1} : 8'd0;
            default: return 8'd0;
        endcase
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison, away from the edge
    always @(posedge clk) begin
        #3;
        if (!rst) begin
            chk(cur_req, bus_rdata, m_rdata());
            chk(cur_req, {7'd0, fail_flag}, {7'd0, m_fail});
        end
    end

    task automatic bus_wr(logic [1:0] s, logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_sel = s; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_reg(logic [1:0] s, string req, logic [7:0] exp);
        @(negedge clk);
        bus_sel = s;
        #1 chk(req, bus_rdata, exp);
    endtask

    // counts cycles with the given control bit high until it drops
    task automatic count_busy(int bitpos, output int n);
        n = 0;
        bus_sel = 2'd2;
        #1;
        while (bus_rdata[bitpos] && n < 200) begin
            n++;
            @(negedge clk);
            #1;
        end
    endtask

    task automatic do_read(logic [5:0] a, string req, logic [7:0] exp);
        int n;
        bus_wr(2'd0, {2'b0, a});
        bus_wr(2'd2, 8'h02);
        bus_wr(2'd2, 8'h03);
        count_busy(0, n);
        rd_reg(2'd1, req, exp);
    endtask

    initial begin : watchdog
        #(200000 * 10);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        cur_req = "R1";
        rd_reg(2'd0, "R1", 8'h00);
        rd_reg(2'd1, "R1", 8'h00);
        rd_reg(2'd2, "R1", 8'h00);
        chk("R1", {7'd0, fail_flag}, 8'h00);
        do_read(6'd17, "R1", 8'h00);

        // R6 write with correct unlock, timed length
        cur_req = "R6";
        bus_wr(2'd0, 8'd5);
        bus_wr(2'd1, 8'hA5);
        bus_wr(2'd2, 8'h08);
        bus_wr(2'd2, 8'h0C);
        count_busy(2, n);
        chk("R6", 8'(n), 8'(WRC));

        // R4 read back, 2-cycle length
        cur_req = "R4";
        bus_wr(2'd1, 8'h00);
        bus_wr(2'd0, 8'd5);
        bus_wr(2'd2, 8'h02);
        bus_wr(2'd2, 8'h03);
        count_busy(0, n);
        chk("R4", 8'(n), 8'(RDC));
        rd_reg(2'd1, "R4", 8'hA5);

        // R3 read start without prior enable
        cur_req = "R3";
        bus_wr(2'd1, 8'h11);
        bus_wr(2'd2, 8'h00);
        bus_wr(2'd2, 8'h03);
        rd_reg(2'd2, "R3", 8'h02);
        repeat (3) @(negedge clk);
        rd_reg(2'd1, "R3", 8'h11);

        // R5 broken unlock orderings
        cur_req = "R5";
        bus_wr(2'd0, 8'd7);
        bus_wr(2'd1, 8'h5A);
        bus_wr(2'd2, 8'h08);
        bus_wr(2'd1, 8'h5A);
        bus_wr(2'd2, 8'h0C);
        rd_reg(2'd2, "R5", 8'h08);
        bus_wr(2'd2, 8'h00);
        bus_wr(2'd2, 8'h0C);
        rd_reg(2'd2, "R5", 8'h08);
        bus_wr(2'd2, 8'h0C);
        rd_reg(2'd2, "R5", 8'h0C);
        count_busy(2, n);
        do_read(6'd7, "R5", 8'h5A);

        // R2 bank gating
        cur_req = "R2";
        bank_sel = 1'b0;
        bus_wr(2'd2, 8'h0A);
        rd_reg(2'd2, "R2", 8'h00);
        rd_reg(2'd3, "R2", 8'h00);
        bank_sel = 1'b1;
        rd_reg(2'd2, "R2", 8'h02);
        bank_sel = 1'b0;
        bus_wr(2'd2, 8'h08);
        bus_wr(2'd2, 8'h0C);
        bank_sel = 1'b1;
        rd_reg(2'd2, "R2", 8'h02);

        // R7 zero clears enables and blocks write-start
        cur_req = "R7";
        bus_wr(2'd2, 8'h0A);
        bus_wr(2'd2, 8'h00);
        rd_reg(2'd2, "R7", 8'h00);
        bus_wr(2'd2, 8'h04);
        rd_reg(2'd2, "R7", 8'h00);

        // R8 busy ignores starts and register changes
        cur_req = "R8";
        bus_wr(2'd0, 8'd20);
        bus_wr(2'd1, 8'hC3);
        bus_wr(2'd2, 8'h08);
        bus_wr(2'd2, 8'h0C);
        bus_wr(2'd0, 8'd21);
        bus_wr(2'd1, 8'h99);
        bus_wr(2'd2, 8'h0A);
        bus_wr(2'd2, 8'h0B);
        rd_reg(2'd2, "R8", 8'h0E);
        count_busy(2, n);
        do_read(6'd20, "R8", 8'hC3);
        do_read(6'd21, "R8", 8'h00);

        // R9 abort of a write and of a read
        cur_req = "R9";
        bus_wr(2'd0, 8'd9);
        bus_wr(2'd1, 8'h3C);
        bus_wr(2'd2, 8'h08);
        bus_wr(2'd2, 8'h0C);
        repeat (5) @(negedge clk);
        lp_req = 1'b1;
        @(negedge clk);
        lp_req = 1'b0;
        rd_reg(2'd2, "R9", 8'h08);
        chk("R9", {7'd0, fail_flag}, 8'h01);
        repeat (40) @(negedge clk);
        bus_wr(2'd1, 8'h77);
        bus_wr(2'd2, 8'h02);
        bus_wr(2'd2, 8'h03);
        chk("R9", {7'd0, fail_flag}, 8'h00);
        lp_req = 1'b1;
        @(negedge clk);
        lp_req = 1'b0;
        rd_reg(2'd1, "R9", 8'h77);
        chk("R9", {7'd0, fail_flag}, 8'h01);
        do_read(6'd9, "R9", 8'h00);

        // R10 idle low-power request
        cur_req = "R10";
        lp_req = 1'b1;
        repeat (4) @(negedge clk);
        lp_req = 1'b0;
        chk("R10", {7'd0, fail_flag}, 8'h00);
        rd_reg(2'd2, "R10", 8'h02);
        do_read(6'd5, "R10", 8'hA5);

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule